// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a memory-mapped windowed watchdog. A slow tick input, nominally 256 pulses per second, drives a down-counter of `CNT_W` bits (12 by default, so the longest timeout is about 16 s). Software keeps the system alive by writing a keyed restart command to the control register. A restart is accepted only inside a window: the counter must already have fallen to the programmed window value or below. A restart that comes too early is a fault. If software never restarts, the counter underflows, and that is also a fault.

After reset, the mode register accepts exactly one write. That write sets the reload value, the window value and the fault routing. The routing choices are:
- raise a level interrupt;
- raise a one-cycle reset request, aimed at either the whole system or the processor alone;
- freeze counting while the system is idle or halted for debug;
- disable the watchdog entirely.

A status register records which fault happened and is cleared by reading it.

Register map (word index on `addr_i`): 0 is mode, 1 is control (write only, reads 0), 2 is status.

Top module: `window_watchdog`

## Requirements
- R1: After reset, the mode register reads 0x3FFF2FFF, status reads 0, and `irq_o`, `sys_rst_o` and `cpu_rst_o` are low.
- R2: Only the first mode write after reset takes effect, and later mode writes are ignored. Mode fields: reload value at bits 11:0, window value at bits 27:16, interrupt enable at bit 12, reset enable at bit 13, processor-only reset at bit 14, disable at bit 15, idle halt at bit 28, debug halt at bit 29. Bits 31:30 read 0.
- R3: While running, each tick decrements the counter. A tick that finds the counter at 0 sets status bit 0 (underflow) and reloads the counter with the reload value. After a reload, the underflow therefore comes on the (reload value + 1)-th tick.
- R4: A control write with 0xA5 in bits 31:24 and bit 0 set is a restart. A control write with any other key is ignored. A restart made while the counter is at or below the window value reloads the counter with the reload value.
- R5: A restart made while the counter is above the window value sets status bit 1 (early restart) and leaves the counter unchanged.
- R6: With the disable bit set, ticks do not count, and neither underflow nor early-restart faults occur.
- R7: Ticks are ignored while `idle_i` is high with idle halt set, or while `debug_i` is high with debug halt set.
- R8: Reading status returns both flags and clears them. A fault arriving in the same cycle as the read stays set.
- R9: `irq_o` is high exactly while a status flag is set and the interrupt enable bit is set.
- R10: Each fault with reset enable set gives a one-cycle pulse. The pulse goes on `cpu_rst_o` when processor-only reset is set, and on `sys_rst_o` otherwise. The two outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow count enable, one cycle per tick |
| idle_i | input | 1 | System idle indication |
| debug_i | input | 1 | Debug halt indication |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid the cycle after `rd_en_i` |
| irq_o | output | 1 | Fault interrupt level |
| sys_rst_o | output | 1 | System reset request pulse |
| cpu_rst_o | output | 1 | Processor-only reset request pulse |

## Verification
The bench builds the block with its default `CNT_W` of 12, so the reset value and the field layout are the full-width ones. It then programs reload values from 3 to 9 and window values inside that range. The bench drives the tick itself, one pulse at a time, so both underflow and the window boundary are reached within a handful of ticks instead of thousands. A seeded random walk of ticks and restarts is scored against a tick-level model of the counter, which covers restarts exactly on the window edge, just inside it and just outside it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam int WDV_LSB   = 0;
  localparam int WDD_LSB   = 16;
  localparam int BIT_IRQEN = 12;
  localparam int BIT_RSTEN = 13;
  localparam int BIT_PROC  = 14;
  localparam int BIT_DIS   = 15;
  localparam int BIT_HIDLE = 28;
  localparam int BIT_HDBG  = 29;
  localparam logic [31:0] MODE_RST  = 32'h3FFF2FFF;
  localparam logic [31:0] MODE_MASK = 32'h3FFFFFFF;
  localparam logic [7:0]  RST_KEY   = 8'hA5;

  typedef enum logic [1:0] {
    A_MODE = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_NONE = 2'd3
  } wdg_addr_e;

  typedef struct packed {
    logic hdbg;
    logic hidle;
    logic dis;
    logic proc;
    logic rsten;
    logic irqen;
  } wdg_ctl_t;
endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
  import wdg_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 2,
  parameter int FLG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [FLG_W-1:0] flags,
  output logic [DW-1:0]    mode_q,
  output logic             mode_load,
  output logic             restart,
  output logic             stat_clr,
  output logic [DW-1:0]    rdata
);
  logic locked;
  wdg_addr_e sel;

  assign sel      = wdg_addr_e'(addr[1:0]);
  assign restart  = wr_en && (sel == A_CTRL) && (wdata[DW-1 -: 8] == RST_KEY) && wdata[0];
  assign stat_clr = rd_en && (sel == A_STAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_RST;
      locked    <= 1'b0;
      mode_load <= 1'b0;
    end else begin
      mode_load <= 1'b0;
      if (wr_en && (sel == A_MODE) && !locked) begin
        mode_q    <= wdata & MODE_MASK;
        locked    <= 1'b1;
        mode_load <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (sel)
        A_MODE:  rdata <= mode_q;
        A_STAT:  rdata <= {{(DW-FLG_W){1'b0}}, flags};
        default: rdata <= '0;
      endcase
    end
  end

  // R2
  mode_lock_chk: assert property (@(posedge clk) disable iff (rst) locked |=> $stable(mode_q));
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             idle,
  input  logic             dbg,
  input  logic [CNT_W-1:0] wdv,
  input  logic [CNT_W-1:0] wdd,
  input  logic             dis,
  input  logic             hidle,
  input  logic             hdbg,
  input  logic             load,
  input  logic             restart,
  output logic             uflow_p,
  output logic             err_p
);
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign run = !dis && !(idle && hidle) && !(dbg && hdbg);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '1;
      uflow_p <= 1'b0;
      err_p   <= 1'b0;
    end else begin
      uflow_p <= 1'b0;
      err_p   <= 1'b0;
      if (load) begin
        cnt <= wdv;
      end else if (restart && !dis) begin
        if (cnt > wdd) err_p <= 1'b1;
        else           cnt   <= wdv;
      end else if (tick && run) begin
        if (cnt == '0) begin
          uflow_p <= 1'b1;
          cnt     <= wdv;
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load && !(restart && !dis)) |=> $stable(cnt));
  // R6
  dis_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    dis |=> (!uflow_p && !err_p));
endmodule

// File: rtl/wdg_fault.sv
module wdg_fault #(
  parameter int FLG_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             uflow_p,
  input  logic             err_p,
  input  logic             clr,
  input  logic             irqen,
  input  logic             rsten,
  input  logic             proc,
  output logic [FLG_W-1:0] flags,
  output logic             irq_o,
  output logic             sys_rst_o,
  output logic             cpu_rst_o
);
  logic [FLG_W-1:0] flags_d;
  logic             fault;

  assign fault   = uflow_p || err_p;
  assign flags_d = (clr ? '0 : flags) | {err_p, uflow_p};

  always_ff @(posedge clk) begin
    if (rst) begin
      flags     <= '0;
      irq_o     <= 1'b0;
      sys_rst_o <= 1'b0;
      cpu_rst_o <= 1'b0;
    end else begin
      flags     <= flags_d;
      irq_o     <= irqen && (|flags_d);
      sys_rst_o <= fault && rsten && !proc;
      cpu_rst_o <= fault && rsten && proc;
    end
  end

  // R10
  rst_excl_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({sys_rst_o, cpu_rst_o}));
  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst) irq_o |-> (flags != '0));
  // R8
  clr_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr && !uflow_p && !err_p) |=> (flags == '0));
endmodule

// File: rtl/window_watchdog.sv
module window_watchdog
  import wdg_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int DW    = 32,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          idle_i,
  input  logic          debug_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o,
  output logic          sys_rst_o,
  output logic          cpu_rst_o
);
  localparam int FLG_W = 2;

  logic [DW-1:0]    mode_q;
  logic             mode_load, restart, stat_clr, uflow_p, err_p;
  logic [FLG_W-1:0] flags;
  wdg_ctl_t         ctl;

  assign ctl = '{hdbg:  mode_q[BIT_HDBG],  hidle: mode_q[BIT_HIDLE],
                 dis:   mode_q[BIT_DIS],   proc:  mode_q[BIT_PROC],
                 rsten: mode_q[BIT_RSTEN], irqen: mode_q[BIT_IRQEN]};

  wdg_regs #(.DW(DW), .AW(AW), .FLG_W(FLG_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en_i), .rd_en(rd_en_i), .addr(addr_i),
    .wdata(wdata_i), .flags(flags), .mode_q(mode_q), .mode_load(mode_load),
    .restart(restart), .stat_clr(stat_clr), .rdata(rdata_o)
  );

  wdg_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick_i), .idle(idle_i), .dbg(debug_i),
    .wdv(mode_q[WDV_LSB +: CNT_W]), .wdd(mode_q[WDD_LSB +: CNT_W]),
    .dis(ctl.dis), .hidle(ctl.hidle), .hdbg(ctl.hdbg),
    .load(mode_load), .restart(restart), .uflow_p(uflow_p), .err_p(err_p)
  );

  wdg_fault #(.FLG_W(FLG_W)) u_fault (
    .clk(clk), .rst(rst), .uflow_p(uflow_p), .err_p(err_p), .clr(stat_clr),
    .irqen(ctl.irqen), .rsten(ctl.rsten), .proc(ctl.proc), .flags(flags),
    .irq_o(irq_o), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
  );
endmodule

// File: tb/window_watchdog_tb.sv
module window_watchdog_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0, idle_i = 1'b0, debug_i = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o, sys_rst_o, cpu_rst_o;

  int checks = 0, fails = 0, cyc = 0;
  int n_sys = 0, n_cpu = 0;

  always #2.5 clk = ~clk;

  window_watchdog u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .idle_i(idle_i), .debug_i(debug_i),
    .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .irq_o(irq_o), .sys_rst_o(sys_rst_o), .cpu_rst_o(cpu_rst_o)
  );

  always @(negedge clk) begin
    cyc++;
    if (sys_rst_o) n_sys++;
    if (cpu_rst_o) n_cpu++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [31:0] mk_mode(int wdv, int wdd, bit irq, bit rse, bit prc,
                                          bit dis, bit hid, bit hdb);
    logic [31:0] m;
    m = '0;
    m[11:0] = wdv[11:0]; m[27:16] = wdd[11:0];
    m[12] = irq; m[13] = rse; m[14] = prc; m[15] = dis; m[28] = hid; m[29] = hdb;
    return m;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk); wr_en_i = 1'b0;
    wait_cyc(3);
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en_i = 1'b1; addr_i = a;
    @(negedge clk); rd_en_i = 1'b0; d = rdata_o;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_i = 1'b1;
      @(negedge clk); tick_i = 1'b0;
    end
    wait_cyc(3);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    wait_cyc(3); rst = 1'b0;
    wait_cyc(2);
  endtask

  localparam logic [31:0] GOOD = 32'hA500_0001;
  localparam logic [31:0] BAD  = 32'h5A00_0001;

  initial begin
    logic [31:0] d, m;
    int s0, c0;
    void'($urandom(32'd7));
    do_reset();

    // R1 reset state
    rd(2'd0, d); chk(d == 32'h3FFF2FFF, "R1 mode reset", d, 32'h3FFF2FFF);
    rd(2'd2, d); chk(d == 0, "R1 status reset", d, 0);
    chk({irq_o, sys_rst_o, cpu_rst_o} == 0, "R1 outputs low", {irq_o, sys_rst_o, cpu_rst_o}, 0);

    // R2 one-time mode write
    m = mk_mode(5, 3, 1, 1, 0, 0, 0, 0);
    wr(2'd0, m);
    rd(2'd0, d); chk(d == m, "R2 first mode write", d, m);
    wr(2'd0, mk_mode(9, 1, 0, 0, 1, 1, 1, 1));
    rd(2'd0, d); chk(d == m, "R2 second write ignored", d, m);

    // R4 wrong key ignored (counter=5 > window 3)
    wr(2'd1, BAD);
    rd(2'd2, d); chk(d == 0, "R4 bad key ignored", d, 0);

    // R5 early restart
    s0 = n_sys;
    wr(2'd1, GOOD);
    chk(irq_o == 1'b1, "R9 irq on fault", irq_o, 1);
    chk(n_sys - s0 == 1, "R10 one system pulse", n_sys - s0, 1);
    rd(2'd2, d); chk(d == 2, "R5 early flag", d, 2);
    wait_cyc(1);
    chk(irq_o == 1'b0, "R9 irq clears with status", irq_o, 0);
    rd(2'd2, d); chk(d == 0, "R8 cleared on read", d, 0);

    // R4 legal restart at window edge (counter=3)
    ticks(2);
    wr(2'd1, GOOD);
    rd(2'd2, d); chk(d == 0, "R4 legal restart no error", d, 0);
    ticks(5);
    rd(2'd2, d); chk(d == 0, "R4 reload observed, no underflow yet", d, 0);
    s0 = n_sys;
    ticks(1);
    rd(2'd2, d); chk(d == 1, "R3 underflow on 6th tick", d, 1);
    chk(n_sys - s0 == 1, "R10 pulse on underflow", n_sys - s0, 1);

    // R6 disable
    do_reset();
    wr(2'd0, mk_mode(3, 0, 1, 1, 0, 1, 0, 0));
    s0 = n_sys;
    ticks(10);
    wr(2'd1, GOOD);
    rd(2'd2, d); chk(d == 0, "R6 disabled no faults", d, 0);
    chk(n_sys - s0 == 0, "R6 no reset pulse", n_sys - s0, 0);

    // R7 halts, R9 irq disabled, R10 processor-only
    do_reset();
    wr(2'd0, mk_mode(3, 3, 0, 1, 1, 0, 1, 1));
    idle_i = 1'b1; ticks(10);
    rd(2'd2, d); chk(d == 0, "R7 idle halt", d, 0);
    idle_i = 1'b0; debug_i = 1'b1; ticks(10);
    rd(2'd2, d); chk(d == 0, "R7 debug halt", d, 0);
    debug_i = 1'b0; ticks(3);
    rd(2'd2, d); chk(d == 0, "R3 three ticks no underflow", d, 0);
    s0 = n_sys; c0 = n_cpu;
    ticks(1);
    chk(irq_o == 1'b0, "R9 irq masked", irq_o, 0);
    chk(n_cpu - c0 == 1, "R10 cpu pulse", n_cpu - c0, 1);
    chk(n_sys - s0 == 0, "R10 no system pulse", n_sys - s0, 0);
    rd(2'd2, d); chk(d == 1, "R3 underflow on 4th tick", d, 1);

    // R3 R4 R5 R8 R9 random walk against a tick model
    for (int run = 0; run < 3; run++) begin
      int wdv, wdd, mc;
      logic [1:0] mf;
      wdv = $urandom_range(9, 3);
      wdd = $urandom_range(wdv, 0);
      do_reset();
      wr(2'd0, mk_mode(wdv, wdd, 1, 1, 0, 0, 0, 0));
      mc = wdv; mf = 0;
      for (int st = 0; st < 40; st++) begin
        if ($urandom_range(3, 0) == 0) begin
          wr(2'd1, GOOD);
          if (mc > wdd) mf[1] = 1'b1; else mc = wdv;
        end else begin
          ticks(1);
          if (mc == 0) begin mf[0] = 1'b1; mc = wdv; end else mc--;
        end
        chk(irq_o == (mf != 0), "R9 random irq", irq_o, mf != 0);
        rd(2'd2, d); chk(d == {30'b0, mf}, "R3/R5 random status", d, {30'b0, mf});
        mf = 0;
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule